// File: doc/BRIEF.md
# Serial Flag-Offset Register Loader

This block holds the two threshold offsets that drive a FIFO's programmable almost-empty and almost-full flags, and lets them be set by a serial bit stream. Both offsets form a single shift chain of twice the offset width. Each write-clock edge that sees the serial enable and the load select high moves one serial bit into the chain. The first bit sent ends up as the least-significant bit of the empty offset. The last bit sent ends up as the most-significant bit of the full offset.

A synchronous master reset puts both offsets back to one of two default values, chosen by a select input during reset. A partial reset restarts the serial position and the read-back sequence but keeps the loaded offsets. A one-cycle completion pulse marks the end of every full chain load. A read-back request returns one offset per request on a parallel output, empty offset first and then full offset, alternating.

Top module: `ofs_serial_loader`

## Requirements
- R1: A serial bit is accepted at a rising clock edge only when `ser_en` and `ser_ld` are both high and `prst` is low; otherwise the offsets keep their value.
- R2: After 2*OFS_W accepted bits, bit k of the stream (k counted from 0) sits in `empty_ofs[k]` for k < OFS_W and in `full_ofs[k-OFS_W]` otherwise. During a load the offsets show the chain as it is shifted: every accepted bit moves all chain bits one place towards `empty_ofs[0]` and enters at `full_ofs[OFS_W-1]`.
- R3: The serial position wraps after 2*OFS_W accepted bits, so the next accepted bit starts a new load.
- R4: While `mrst` is high at a clock edge, both offsets become DFLT_HI if `dflt_sel` is 1, or DFLT_LO if it is 0. The same edge clears the serial position and the read-back sequence, and drives `load_done` and `rd_valid` to 0. `mrst` has priority over every other input.
- R5: `prst` high at a clock edge clears the serial position and the read-back sequence and clears `load_done` and `rd_valid`. It leaves both offsets unchanged and blocks any shift on that edge.
- R6: `load_done` is high for exactly the one cycle after the edge that accepted the final (2*OFS_W-th) bit of a load.
- R7: When `ser_en` or `ser_ld` is low, the serial position holds. A load that resumes later continues from the held position.
- R8: `rd_req` high at an edge (without either reset) makes `rd_valid` 1 in the next cycle. In that cycle `rd_data` carries the offset value from before that edge. The first request after any reset returns the empty offset, the second returns the full offset, and further requests alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| dflt_sel | input | 1 | Default select sampled during master reset (1 = DFLT_HI) |
| ser_en | input | 1 | Serial enable |
| ser_ld | input | 1 | Load select |
| ser_bit | input | 1 | Serial data bit |
| rd_req | input | 1 | Read-back request, one offset per request |
| empty_ofs | output | OFS_W | Current empty offset |
| full_ofs | output | OFS_W | Current full offset |
| load_done | output | 1 | One-cycle pulse after the final chain bit |
| rd_valid | output | 1 | Read-back data valid |
| rd_data | output | OFS_W | Read-back offset value |

## Verification
The bench goes after the seam between the two offsets. If the bit order were wrong or the chain were split, the bits sent at positions OFS_W-1 and OFS_W would land in the wrong register. It also covers a load that is paused and resumed, and a partial reset in the middle of a load. A design that cleared the position on pause, or wiped the offsets on partial reset, would end up with shifted or default offsets instead of the pattern that was sent. Loads that run past the chain length check that the completion pulse comes once per load and that the position wraps. Read-backs issued before and after resets check that the empty offset always comes first and that each returned value is the one from the request edge.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  // Which offset the next read-back request returns
  typedef enum logic {
    RB_EMPTY = 1'b0,
    RB_FULL  = 1'b1
  } rb_sel_e;

  // Number of serial bits in one complete load
  function automatic int unsigned chain_len(input int unsigned w);
    return 2 * w;
  endfunction

  // Reset default chosen by the select input
  function automatic logic [31:0] pick_default(input logic sel,
                                               input logic [31:0] lo,
                                               input logic [31:0] hi);
    return sel ? hi : lo;
  endfunction

endpackage

// File: rtl/ofsld_chain.sv
module ofsld_chain
  import ofsld_pkg::*;
#(
  parameter int unsigned OFS_W   = 17,
  parameter int unsigned DFLT_LO = 32'h0000_007F,
  parameter int unsigned DFLT_HI = 32'h0000_03FF
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             dflt_sel,
  input  logic             shift_fire,
  input  logic             ser_bit,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  localparam int unsigned LEN = chain_len(OFS_W);

  logic [LEN-1:0]   chain_q;
  logic [OFS_W-1:0] dflt_val;

  assign dflt_val = OFS_W'(pick_default(dflt_sel, DFLT_LO, DFLT_HI));

  always_ff @(posedge clk) begin
    if (mrst) begin
      chain_q <= {dflt_val, dflt_val};
    end else if (shift_fire) begin
      chain_q <= {ser_bit, chain_q[LEN-1:1]};
    end
  end

  assign empty_ofs = chain_q[OFS_W-1:0];
  assign full_ofs  = chain_q[LEN-1:OFS_W];

  // Without a shift or master reset the chain must not move
  assert_hold_R1: assert property (@(posedge clk) disable iff (mrst)
    !shift_fire |=> $stable(chain_q));

  // A shift places the new bit at the chain head
  assert_head_R2: assert property (@(posedge clk) disable iff (mrst)
    shift_fire |=> (full_ofs[OFS_W-1] == $past(ser_bit)));

endmodule

// File: rtl/ofsld_bitpos.sv
module ofsld_bitpos #(
  parameter int unsigned LEN = 34
) (
  input  logic clk,
  input  logic mrst,
  input  logic prst,
  input  logic shift_fire,
  output logic load_done
);
  localparam int unsigned PW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  logic [PW-1:0] pos_q;
  logic          done_q;
  logic          final_bit;

  assign final_bit = shift_fire && (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_bit;
      if (shift_fire) begin
        pos_q <= final_bit ? '0 : pos_q + 1'b1;
      end
    end
  end

  assign load_done = done_q;

  // Completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (mrst)
    load_done |=> !load_done);

  // Partial reset restarts the position
  assert_prst_clear_R5: assert property (@(posedge clk) disable iff (mrst)
    prst |=> (pos_q == '0));

  // Position holds while no bit is accepted
  assert_pos_hold_R7: assert property (@(posedge clk) disable iff (mrst)
    (!shift_fire && !prst) |=> $stable(pos_q));

  // Position wraps after the final bit
  assert_wrap_R3: assert property (@(posedge clk) disable iff (mrst)
    (final_bit && !prst) |=> (pos_q == '0));

endmodule

// File: rtl/ofsld_readback.sv
module ofsld_readback
  import ofsld_pkg::*;
#(
  parameter int unsigned OFS_W = 17
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             rd_req,
  input  logic [OFS_W-1:0] empty_ofs,
  input  logic [OFS_W-1:0] full_ofs,
  output logic             rd_valid,
  output logic [OFS_W-1:0] rd_data
);
  rb_sel_e          rptr_q;
  logic             valid_q;
  logic [OFS_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      rptr_q  <= RB_EMPTY;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_req;
      if (rd_req) begin
        data_q <= (rptr_q == RB_FULL) ? full_ofs : empty_ofs;
        rptr_q <= (rptr_q == RB_FULL) ? RB_EMPTY : RB_FULL;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  // Every request yields a valid word next cycle
  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (mrst)
    (rd_req && !prst) |=> rd_valid);

  // The selected register alternates per request
  assert_rptr_alt_R8: assert property (@(posedge clk) disable iff (mrst)
    (rd_req && !prst) |=> (rptr_q != $past(rptr_q)));

endmodule

// File: rtl/ofs_serial_loader.sv
module ofs_serial_loader
  import ofsld_pkg::*;
#(
  parameter int unsigned OFS_W   = 17,
  parameter int unsigned DFLT_LO = 32'h0000_007F,
  parameter int unsigned DFLT_HI = 32'h0000_03FF
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             dflt_sel,
  input  logic             ser_en,
  input  logic             ser_ld,
  input  logic             ser_bit,
  input  logic             rd_req,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             load_done,
  output logic             rd_valid,
  output logic [OFS_W-1:0] rd_data
);
  localparam int unsigned LEN = chain_len(OFS_W);

  // Named event: one serial bit accepted at this edge
  logic shift_fire;
  assign shift_fire = ser_en && ser_ld && !prst;

  ofsld_chain #(
    .OFS_W  (OFS_W),
    .DFLT_LO(DFLT_LO),
    .DFLT_HI(DFLT_HI)
  ) chain_i (
    .clk       (clk),
    .mrst      (mrst),
    .dflt_sel  (dflt_sel),
    .shift_fire(shift_fire),
    .ser_bit   (ser_bit),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  ofsld_bitpos #(
    .LEN(LEN)
  ) bitpos_i (
    .clk       (clk),
    .mrst      (mrst),
    .prst      (prst),
    .shift_fire(shift_fire),
    .load_done (load_done)
  );

  ofsld_readback #(
    .OFS_W(OFS_W)
  ) readback_i (
    .clk      (clk),
    .mrst     (mrst),
    .prst     (prst),
    .rd_req   (rd_req),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // Partial reset must not disturb the offsets
  assert_prst_keep_R5: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

// File: tb/ofs_serial_loader_tb_top.sv
module ofs_serial_loader_tb_top;
  localparam int W    = 17;
  localparam int LEN  = 2 * W;
  localparam int DLO  = 32'h7F;
  localparam int DHI  = 32'h3FF;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, dflt_sel = 1'b0;
  logic ser_en = 1'b0, ser_ld = 1'b0, ser_bit = 1'b0, rd_req = 1'b0;
  logic [W-1:0] empty_ofs, full_ofs, rd_data;
  logic load_done, rd_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ofs_serial_loader #(.OFS_W(W), .DFLT_LO(DLO), .DFLT_HI(DHI)) dut_i (
    .clk(clk), .mrst(mrst), .prst(prst), .dflt_sel(dflt_sel),
    .ser_en(ser_en), .ser_ld(ser_ld), .ser_bit(ser_bit), .rd_req(rd_req),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .load_done(load_done),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // ---------------- reference model ----------------
  bit q[$];          // q[i] is chain bit i, q[0] = empty LSB
  int seq_pos;       // bits accepted in the current load
  bit rp_full;
  bit m_done, m_rv;
  logic [W-1:0] m_rd;
  bit m_live = 1'b0;

  function automatic logic [W-1:0] m_empty();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = q[i];
    return r;
  endfunction

  function automatic logic [W-1:0] m_full();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = q[W + i];
    return r;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] e_now, f_now;
    e_now = m_empty();
    f_now = m_full();
    if (mrst) begin
      int dv;
      dv = dflt_sel ? DHI : DLO;
      q.delete();
      for (int i = 0; i < LEN; i++) q.push_back(dv[i % W]);
      seq_pos = 0; rp_full = 0; m_done = 0; m_rv = 0; m_rd = '0;
      m_live = 1'b1;
    end else if (prst) begin
      seq_pos = 0; rp_full = 0; m_done = 0; m_rv = 0; m_rd = '0;
    end else begin
      m_done = 0;
      if (ser_en && ser_ld) begin
        void'(q.pop_front());
        q.push_back(ser_bit);
        seq_pos++;
        if (seq_pos == LEN) begin
          seq_pos = 0;
          m_done = 1;
        end
      end
      m_rv = rd_req;
      if (rd_req) begin
        m_rd = rp_full ? f_now : e_now;
        rp_full = !rp_full;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_live && !finished) begin
      check("R2", "empty_ofs", 32'(empty_ofs), 32'(m_empty()));
      check("R2", "full_ofs",  32'(full_ofs),  32'(m_full()));
      check("R6", "load_done", 32'(load_done), 32'(m_done));
      check("R8", "rd_valid",  32'(rd_valid),  32'(m_rv));
      if (m_rv) check("R8", "rd_data", 32'(rd_data), 32'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_bits(input logic [LEN-1:0] stream, input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      ser_en = 1'b1; ser_ld = 1'b1; ser_bit = stream[i];
      @(negedge clk);
    end
    ser_en = 1'b0; ser_ld = 1'b0; ser_bit = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [W-1:0] ea, fa, eb, fb;

  initial begin
    ea = 17'h1A5C3; fa = 17'h0F0F1;
    eb = 17'h13579; fb = 17'h1BDF0;
    mrst = 1'b1; dflt_sel = 1'b0;
    idle(2);
    mrst = 1'b0;
    // R4: low default
    check("R4", "empty default lo", 32'(empty_ofs), DLO);
    check("R4", "full default lo",  32'(full_ofs),  DLO);
    check("R4", "done after reset", 32'(load_done), 0);

    // R2 / R6: full load, then the pulse
    send_bits({fa, ea}, 0, LEN);
    check("R6", "done pulse", 32'(load_done), 1);
    check("R2", "empty loaded", 32'(empty_ofs), 32'(ea));
    check("R2", "full loaded",  32'(full_ofs),  32'(fa));
    idle(1);
    check("R6", "done dropped", 32'(load_done), 0);

    // R1: only one of the two enables high: ignored
    ser_en = 1'b1; ser_ld = 1'b0; ser_bit = 1'b1; idle(3);
    ser_en = 1'b0; ser_ld = 1'b1; ser_bit = 1'b0; idle(3);
    ser_ld = 1'b0;
    check("R1", "empty unchanged", 32'(empty_ofs), 32'(ea));
    check("R1", "full unchanged",  32'(full_ofs),  32'(fa));

    // R8: read-back order empty, full, empty
    rd_req = 1'b1; idle(1);
    check("R8", "first read empty", 32'(rd_data), 32'(ea));
    idle(1);
    check("R8", "second read full", 32'(rd_data), 32'(fa));
    idle(1);
    rd_req = 1'b0;
    check("R8", "third read empty", 32'(rd_data), 32'(ea));

    // R7: pause mid-load, then resume
    send_bits({fb, eb}, 0, 10);
    idle(5);
    send_bits({fb, eb}, 10, LEN - 10);
    check("R7", "resumed empty", 32'(empty_ofs), 32'(eb));
    check("R7", "resumed full",  32'(full_ofs),  32'(fb));
    check("R7", "resumed done",  32'(load_done), 1);

    // R5: partial reset mid-load keeps offsets, restarts position
    send_bits({fa, ea}, 0, 5);
    prst = 1'b1; ser_en = 1'b1; ser_ld = 1'b1; ser_bit = 1'b1;
    idle(1);
    prst = 1'b0; ser_en = 1'b0; ser_ld = 1'b0;
    rd_req = 1'b1; idle(1); rd_req = 1'b0;
    check("R5", "read seq restarted", 32'(rd_data), 32'(m_empty()));
    send_bits({fa, ea}, 0, LEN);
    check("R5", "reload after prst empty", 32'(empty_ofs), 32'(ea));
    check("R5", "reload after prst full",  32'(full_ofs),  32'(fa));

    // R3: run past the chain length; next load starts fresh
    send_bits({fb, eb}, 0, 3);
    send_bits({fb, eb}, 3, LEN - 3);
    check("R3", "wrap empty", 32'(empty_ofs), 32'(eb));
    check("R3", "wrap full",  32'(full_ofs),  32'(fb));

    // R4: master reset with high default mid-load
    send_bits({fa, ea}, 0, 7);
    mrst = 1'b1; dflt_sel = 1'b1; idle(1);
    mrst = 1'b0; dflt_sel = 1'b0;
    check("R4", "empty default hi", 32'(empty_ofs), DHI);
    check("R4", "full default hi",  32'(full_ofs),  DHI);
    send_bits({fb, eb}, 0, LEN);
    check("R4", "position cleared by mrst", 32'(full_ofs), 32'(fb));
    idle(3);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule